// File: doc/BRIEF.md
# CPU Clock Rate-Change Sequencer

This block steps the clock controller of a CPU domain safely through a change of PLL frequency. Before the PLL is retuned, a pre-change request supplies the current and future PLL rates, the rate of the alternate clock source and the target divider words. The sequencer then walks through its write steps on a simple register write port. If needed, it first applies a protective divider so the CPU clock never runs faster than the slower of the two PLL rates. It then parks the CPU clock mux on the alternate source and installs the final divider words.

After the PLL has relocked, a post-change request returns the mux to the PLL and removes the protective divider. Every write is followed by a poll of a status input. The poll is bounded by a cycle-count timeout, and when it expires the block records an error and carries on.

The block owns the only copies of the divider words it writes. Its read-modify-write operations work on internal shadows of what it last wrote. Both shadows reset to zero.

Top module: `cpu_clk_seq`

## Requirements
- R1: After reset `busy`, `ack`, `wr_en`, `err_timeout` and `warn_div` are all 0.
- R2: On a pre-change request the protective divider step is taken only when `alt_rate > old_rate` or `old_rate > new_rate`. Otherwise the first write is the mux write (`wr_sel` = 0).
- R3: The protective value is ceil(`alt_rate` / min(`old_rate`, `new_rate`)) − 1, placed in divider-word-0 bits [2:0]. A result of 8 or more saturates the field at 7 and sets `warn_div` until the next accepted request.
- R4: With `DBG_EN` set, bits [18:16] of divider word 0 are forced to 7 together with the protective value, and they are part of its write mask.
- R5: The protective write (`wr_sel` = 1) changes only the masked bits of the last written word 0. The sequencer then waits until `div0_stat` is zero under that mask.
- R6: The mux write (`wr_sel` = 0, `wr_data[0]` = 1 selects the alternate source) is followed by a wait until `mux_stat` equals 2. Transitional values do not end the wait.
- R7: Next, word 0 is written with the target ORed with the protective word, and the sequencer waits for all `div0_stat` bits to be zero. Then word 1 (`wr_sel` = 2) is written, and the sequencer waits for all `div1_stat` bits to be zero. Each write lasts exactly one cycle.
- R8: A post-change request writes the mux with `wr_data[0]` = 0 and waits for `mux_stat` equal to 1. It then rewrites word 0 with bits [2:0] cleared and bits [18:16] taken from `tgt_div0`, leaving all other bits unchanged.
- R9: When `mon_src_alt` is 1, bits [6:4] and [2:0] of word 1 keep their previously written values, and the rest comes from `tgt_div1`.
- R10: A wait that exceeds `TIMEOUT_CYC` cycles sets `err_timeout`, and the sequence continues to completion. `err_timeout` clears when the next request is accepted.
- R11: `ack` pulses high for exactly one cycle at the end of each sequence. A request that arrives while `busy` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_post | input | 1 | 0 = pre-change, 1 = post-change |
| old_rate | input | RATE_W | Current PLL rate |
| new_rate | input | RATE_W | Future PLL rate |
| alt_rate | input | RATE_W | Alternate source rate |
| tgt_div0 | input | WORD_W | Target divider word 0 |
| tgt_div1 | input | WORD_W | Target divider word 1 |
| mon_src_alt | input | 1 | Monitor clock not fed from the PLL |
| busy | output | 1 | Sequence in progress |
| ack | output | 1 | One-cycle completion pulse |
| wr_en | output | 1 | Register write strobe |
| wr_sel | output | 2 | 0 mux, 1 divider word 0, 2 divider word 1 |
| wr_data | output | WORD_W | Register write data |
| mux_stat | input | 3 | Mux status field |
| div0_stat | input | WORD_W | Divider word 0 busy bits |
| div1_stat | input | WORD_W | Divider word 1 busy bits |
| err_timeout | output | 1 | A status wait expired |
| warn_div | output | 1 | Protective divider saturated |

## Verification
The hardest situation to reach is a status wait that runs out. Every status model that behaves well settles long before the limit. The bench therefore builds with a short timeout and, for one sequence, holds the word-1 busy bits high. It then checks that the error flag is set, that the acknowledge still arrives, and that the next request clears the flag. The mux model also passes through a transitional code, after a random delay, before it settles, so a wait that exits early would show up as a write out of order.

// File: rtl/cpu_clk_seq.sv
module cpu_clk_seq #(
  parameter int RATE_W      = 32,
  parameter int WORD_W      = 32,
  parameter int TIMEOUT_CYC = 2_000_000,
  parameter bit HAS_DIV1    = 1'b1,
  parameter bit DBG_EN      = 1'b1,
  parameter int DBG_LSB     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_post,
  input  logic [RATE_W-1:0] old_rate,
  input  logic [RATE_W-1:0] new_rate,
  input  logic [RATE_W-1:0] alt_rate,
  input  logic [WORD_W-1:0] tgt_div0,
  input  logic [WORD_W-1:0] tgt_div1,
  input  logic              mon_src_alt,
  output logic              busy,
  output logic              ack,
  output logic              wr_en,
  output logic [1:0]        wr_sel,
  output logic [WORD_W-1:0] wr_data,
  input  logic [2:0]        mux_stat,
  input  logic [WORD_W-1:0] div0_stat,
  input  logic [WORD_W-1:0] div1_stat,
  output logic              err_timeout,
  output logic              warn_div
);
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(TIMEOUT_CYC - 1);
  localparam logic [WORD_W-1:0] SAFE_FLD = WORD_W'(7);
  localparam logic [WORD_W-1:0] DBG_FLD  = DBG_EN ? (WORD_W'(7) << DBG_LSB) : '0;
  localparam logic [WORD_W-1:0] SAFE_MSK = SAFE_FLD | DBG_FLD;
  localparam logic [WORD_W-1:0] KEEP1    = WORD_W'(8'h77);
  localparam int PW = RATE_W + 4;

  typedef enum logic [3:0] {
    S_IDLE, S_PLAN, S_SAFE_W, S_SAFE_P, S_ALT_W, S_ALT_P, S_D0_W, S_D0_P,
    S_D1_W, S_D1_P, S_PLL_W, S_PLL_P, S_CLR_W, S_CLR_P, S_DONE
  } st_t;

  st_t               state;
  logic [RATE_W-1:0] old_q, new_q, alt_q;
  logic [WORD_W-1:0] t0_q, t1_q, sh0, sh1;
  logic              mon_q;
  logic [CNT_W-1:0]  cnt;
  logic              err_q, warn_q;

  logic [RATE_W-1:0] min_rate;
  logic [3:0]        over_cnt;
  logic              use_safe;
  logic [2:0]        sd;
  logic [WORD_W-1:0] safe_val, d1_val;
  logic              poll_ok;
  st_t               poll_next;

  assign min_rate = (old_q < new_q) ? old_q : new_q;
  assign use_safe = (alt_q > old_q) || (old_q > new_q);

  always_comb begin
    over_cnt = '0;
    for (int k = 1; k <= 8; k++)
      if (({4'b0, min_rate} * PW'(k)) < {4'b0, alt_q})
        over_cnt = over_cnt + 4'd1;
  end

  assign sd       = over_cnt[3] ? 3'd7 : over_cnt[2:0];
  assign safe_val = use_safe ? (WORD_W'(sd) | DBG_FLD) : '0;
  assign d1_val   = mon_q ? ((t1_q & ~KEEP1) | (sh1 & KEEP1)) : t1_q;

  assign busy        = (state != S_IDLE);
  assign ack         = (state == S_DONE);
  assign err_timeout = err_q;
  assign warn_div    = warn_q;

  always_comb begin
    wr_en   = 1'b1;
    wr_sel  = 2'd1;
    wr_data = '0;
    case (state)
      S_SAFE_W: wr_data = (sh0 & ~SAFE_MSK) | (safe_val & SAFE_MSK);
      S_ALT_W:  begin wr_sel = 2'd0; wr_data = WORD_W'(1); end
      S_D0_W:   wr_data = t0_q | safe_val;
      S_D1_W:   begin wr_sel = 2'd2; wr_data = d1_val; end
      S_PLL_W:  wr_sel = 2'd0;
      S_CLR_W:  wr_data = (sh0 & ~SAFE_MSK) | (t0_q & DBG_FLD);
      default:  begin wr_en = 1'b0; wr_sel = 2'd0; end
    endcase
  end

  always_comb begin
    poll_ok   = 1'b0;
    poll_next = S_DONE;
    case (state)
      S_SAFE_P: begin poll_ok = (div0_stat & SAFE_MSK) == '0; poll_next = S_ALT_W; end
      S_ALT_P:  begin poll_ok = (mux_stat == 3'd2); poll_next = S_D0_W; end
      S_D0_P:   begin poll_ok = (div0_stat == '0); poll_next = HAS_DIV1 ? S_D1_W : S_DONE; end
      S_D1_P:   poll_ok = (div1_stat == '0);
      S_PLL_P:  begin poll_ok = (mux_stat == 3'd1); poll_next = S_CLR_W; end
      S_CLR_P:  poll_ok = (div0_stat & SAFE_MSK) == '0;
      default:  ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      old_q  <= '0;
      new_q  <= '0;
      alt_q  <= '0;
      t0_q   <= '0;
      t1_q   <= '0;
      mon_q  <= 1'b0;
      sh0    <= '0;
      sh1    <= '0;
      cnt    <= '0;
      err_q  <= 1'b0;
      warn_q <= 1'b0;
    end else begin
      if (wr_en && wr_sel == 2'd1) sh0 <= wr_data;
      if (wr_en && wr_sel == 2'd2) sh1 <= wr_data;
      case (state)
        S_IDLE: if (req_valid) begin
          old_q  <= old_rate;
          new_q  <= new_rate;
          alt_q  <= alt_rate;
          t0_q   <= tgt_div0;
          t1_q   <= tgt_div1;
          mon_q  <= mon_src_alt;
          err_q  <= 1'b0;
          warn_q <= 1'b0;
          state  <= req_post ? S_PLL_W : S_PLAN;
        end
        S_PLAN: begin
          warn_q <= use_safe && over_cnt[3];
          state  <= use_safe ? S_SAFE_W : S_ALT_W;
        end
        S_SAFE_W, S_ALT_W, S_D0_W, S_D1_W, S_PLL_W, S_CLR_W: begin
          cnt   <= CNT_LOAD;
          state <= st_t'(state + 4'd1);
        end
        S_SAFE_P, S_ALT_P, S_D0_P, S_D1_P, S_PLL_P, S_CLR_P: begin
          if (poll_ok || cnt == '0) begin
            if (!poll_ok) err_q <= 1'b1;
            state <= poll_next;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module cpu_clk_seq_chk #(
  parameter int RATE_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_post,
  input logic [RATE_W-1:0] old_rate,
  input logic [RATE_W-1:0] new_rate,
  input logic [RATE_W-1:0] alt_rate,
  input logic              busy,
  input logic              ack,
  input logic              wr_en,
  input logic [1:0]        wr_sel,
  input logic              wr_bit0,
  input logic [2:0]        mux_stat,
  input logic              err_timeout
);
  logic       cond_q, first_q, mux_pend_q;
  logic [2:0] mux_goal_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cond_q     <= 1'b0;
      first_q    <= 1'b0;
      mux_pend_q <= 1'b0;
      mux_goal_q <= 3'd1;
    end else begin
      if (req_valid && !busy && !req_post) begin
        cond_q  <= (alt_rate > old_rate) || (old_rate > new_rate);
        first_q <= 1'b1;
      end else if (wr_en) begin
        first_q <= 1'b0;
      end
      if (wr_en && wr_sel == 2'd0) begin
        mux_pend_q <= 1'b1;
        mux_goal_q <= wr_bit0 ? 3'd2 : 3'd1;
      end else if (wr_en) begin
        mux_pend_q <= 1'b0;
      end
    end
  end

  // R2
  safe_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && first_q && !cond_q) |-> (wr_sel == 2'd0));

  // R6
  mux_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && mux_pend_q) |-> ($past(mux_stat) == mux_goal_q || err_timeout));

  // R7
  wr_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  // R11
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!wr_en && !ack));
endmodule

bind cpu_clk_seq cpu_clk_seq_chk #(.RATE_W(RATE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_post(req_post),
  .old_rate(old_rate), .new_rate(new_rate), .alt_rate(alt_rate),
  .busy(busy), .ack(ack), .wr_en(wr_en), .wr_sel(wr_sel), .wr_bit0(wr_data[0]),
  .mux_stat(mux_stat), .err_timeout(err_timeout)
);

// File: tb/tb_cpu_clk_seq.sv
`timescale 1ns/1ps
module tb_cpu_clk_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_post = 1'b0, mon_src_alt = 1'b0;
  logic [31:0] old_rate = '0, new_rate = '0, alt_rate = '0;
  logic [31:0] tgt_div0 = '0, tgt_div1 = '0;
  logic        busy, ack, wr_en, err_timeout, warn_div;
  logic [1:0]  wr_sel;
  logic [31:0] wr_data;
  logic [2:0]  mux_stat = 3'd1, mux_goal = 3'd1;
  logic [31:0] div0_stat = '0, div1_stat = '0;
  int          mux_cnt = 0, d0_cnt = 0, d1_cnt = 0;
  bit          stuck_d1 = 1'b0;

  int n_chk = 0, n_bad = 0;
  logic [1:0]  sel_q[$];
  logic [31:0] dat_q[$];
  string       tag_q[$];
  logic [31:0] sh0 = '0, sh1 = '0;

  always #2.5 clk = ~clk;

  cpu_clk_seq #(.TIMEOUT_CYC(40)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_post(req_post),
    .old_rate(old_rate), .new_rate(new_rate), .alt_rate(alt_rate),
    .tgt_div0(tgt_div0), .tgt_div1(tgt_div1), .mon_src_alt(mon_src_alt),
    .busy(busy), .ack(ack), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .mux_stat(mux_stat), .div0_stat(div0_stat), .div1_stat(div1_stat),
    .err_timeout(err_timeout), .warn_div(warn_div)
  );

  // status models: random settle delays, transitional mux code 3
  always @(posedge clk) begin
    if (wr_en && wr_sel == 2'd0) begin
      mux_stat <= 3'd3;
      mux_goal <= wr_data[0] ? 3'd2 : 3'd1;
      mux_cnt  <= $urandom_range(1, 10);
    end else if (mux_cnt > 1) mux_cnt <= mux_cnt - 1;
    else begin mux_cnt <= 0; mux_stat <= mux_goal; end

    if (wr_en && wr_sel == 2'd1) begin
      div0_stat <= 32'h0007_0007;
      d0_cnt    <= $urandom_range(1, 10);
    end else if (d0_cnt > 1) d0_cnt <= d0_cnt - 1;
    else begin d0_cnt <= 0; div0_stat <= '0; end

    if (wr_en && wr_sel == 2'd2) begin
      div1_stat <= 32'h0000_0077;
      d1_cnt    <= $urandom_range(1, 10);
    end else if (d1_cnt > 1) d1_cnt <= d1_cnt - 1;
    else begin d1_cnt <= 0; if (!stuck_d1) div1_stat <= '0; end
  end

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      if (sel_q.size() == 0) begin
        check(1'b0, "R11", "unexpected write", {wr_sel, wr_data}, 0);
      end else begin
        automatic logic [1:0]  es = sel_q.pop_front();
        automatic logic [31:0] ed = dat_q.pop_front();
        automatic string       et = tag_q.pop_front();
        check(wr_sel == es && wr_data == ed, et, "write sel/data",
              {wr_sel, wr_data}, {es, ed});
      end
    end
  end

  task automatic push(logic [1:0] s, logic [31:0] d, string t);
    sel_q.push_back(s); dat_q.push_back(d); tag_q.push_back(t);
  endtask

  task automatic run_req(bit post, logic [31:0] o, logic [31:0] n, logic [31:0] a,
                         logic [31:0] t0, logic [31:0] t1, bit mon,
                         bit exp_err, bit poke, string tag);
    longint mn, q;
    bit use_s, exp_warn;
    logic [31:0] sv, w, d1;
    exp_warn = 1'b0;
    if (!post) begin
      mn    = (o < n) ? o : n;
      use_s = (a > o) || (o > n);
      q     = (mn == 0) ? 8 : ((longint'(a) + mn - 1) / mn) - 1;
      if (q < 0) q = 0;
      exp_warn = use_s && (q >= 8);
      sv = use_s ? ((q > 7 ? 32'd7 : 32'(q)) | 32'h0007_0000) : 32'd0;
      if (use_s) begin
        w = (sh0 & ~32'h0007_0007) | sv;   // R3 R4 R5
        push(2'd1, w, "R5"); sh0 = w;
      end
      push(2'd0, 32'd1, "R6");             // R2: mux first when no protective step
      w = t0 | sv; push(2'd1, w, "R7"); sh0 = w;
      d1 = mon ? ((t1 & ~32'h77) | (sh1 & 32'h77)) : t1;  // R9
      push(2'd2, d1, mon ? "R9" : "R7"); sh1 = d1;
    end else begin
      push(2'd0, 32'd0, "R8");
      w = (sh0 & ~32'h0007_0007) | (t0 & 32'h0007_0000);
      push(2'd1, w, "R8"); sh0 = w;
    end
    @(negedge clk);
    req_valid = 1'b1; req_post = post; old_rate = o; new_rate = n; alt_rate = a;
    tgt_div0 = t0; tgt_div1 = t1; mon_src_alt = mon;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      check(busy == 1'b1, "R11", "busy during sequence", busy, 1);
      req_valid = 1'b1; req_post = 1'b1; tgt_div0 = 32'hFFFF_FFFF;
      @(negedge clk);
      req_valid = 1'b0;
    end
    for (int i = 0; i < 2000 && !ack; i++) @(negedge clk);
    check(ack == 1'b1, tag, "ack seen", ack, 1);
    check(err_timeout == exp_err, "R10", "timeout flag", err_timeout, exp_err);
    check(warn_div == exp_warn, "R3", "warn flag", warn_div, exp_warn);
    @(negedge clk);
    check(ack == 1'b0, "R11", "ack one cycle", ack, 0);
    check(sel_q.size() == 0, tag, "pending writes", sel_q.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!busy && !ack && !wr_en && !err_timeout && !warn_div, "R1", "reset outputs",
          {busy, ack, wr_en, err_timeout, warn_div}, 0);
    // R2 no protective step
    run_req(0, 800, 1000, 400, 32'h0012_3450, 32'h0000_0123, 0, 0, 0, "R2");
    // R8 return to PLL
    run_req(1, 0, 0, 0, 32'h0015_0000, 0, 0, 0, 0, "R8");
    // R5 downward change, value 1, with an ignored request mid-way (R11)
    run_req(0, 1000, 500, 800, 32'h0031_2200, 32'h0000_0456, 0, 0, 1, "R5");
    repeat (20) @(negedge clk);
    check(busy == 1'b0, "R11", "idle after ignored request", busy, 0);
    run_req(1, 0, 0, 0, 32'h0062_0000, 0, 0, 0, 0, "R8");
    // R3 saturation: ceil(10000/1000)-1 = 9
    run_req(0, 1000, 1200, 10000, 32'h0000_0010, 32'h0000_0700, 0, 0, 0, "R3");
    run_req(1, 0, 0, 0, 32'h0003_0000, 0, 0, 0, 0, "R8");
    // R3 exact ratio boundary: 1000/500 -> 1
    run_req(0, 500, 500, 1000, 32'h0000_1000, 32'h0000_0123, 0, 0, 0, "R3");
    run_req(1, 0, 0, 0, 32'h0000_0000, 0, 0, 0, 0, "R4");
    // R3 just above boundary: 1001/500 -> 2, with R9 field preservation
    run_req(0, 500, 500, 1001, 32'h0000_2000, 32'h0000_0456, 1, 0, 0, "R9");
    run_req(1, 0, 0, 0, 32'h0001_0000, 0, 0, 0, 0, "R8");
    // R10 word-1 status never settles
    stuck_d1 = 1'b1;
    run_req(0, 800, 900, 300, 32'h0000_0300, 32'h0000_0011, 0, 1, 0, "R10");
    stuck_d1 = 1'b0;
    repeat (3) @(negedge clk);
    run_req(1, 0, 0, 0, 32'h0000_0000, 0, 0, 0, 0, "R10");
    repeat (10) @(negedge clk);
    check(!busy && !wr_en, "R11", "final idle", {busy, wr_en}, 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule